// File: doc/BRIEF.md
# Flash Write-Protection Controller

This block holds the protection state of a serial flash status register. It decides whether each request that would change the array may go ahead. The state is a two-bit protection code and a lock bit. A write-status request, carrying a data byte, updates that state. An external active-low write-protect pin gates those updates: when the pin is low and the lock bit is set, the protection state is frozen.

Each program, sector-erase or chip-erase request is checked against the current protection code. The block answers the cycle after the request with a one-cycle grant pulse or a one-cycle deny pulse. The protected window always ends at the top of the array. Its lower bound is published as an output, and it is derived from the array-size parameter (`ADDR_W` address bits, so the array holds 2^ADDR_W bytes).

The command decoder, the array itself and the program and erase timing sit outside this block. Power-up is modelled by a synchronous active-high reset.

Top module: `flash_wp_ctrl`

## Requirements
- R1: Protection code 00 gives no window (`winActive`=0). Code 01 gives a window starting at three quarters of the array size. Code 10 gives a window starting at half the array size. Code 11 gives a window starting at address 0. In each case the window extends to the last array address. For a 64 KB array, codes 01 and 10 start at 0x00C000 and 0x008000.
- R2: A program (`opType`=00) or sector-erase (`opType`=01) request is denied when the window is active and `opAddr` is greater than or equal to `winLo`. Otherwise it is granted.
- R3: Reset sets the protection code to 11 and the lock bit to 0, and leaves `grant` and `deny` low.
- R4: A write-status request is accepted when `wpN` is high or the lock bit is 0. On acceptance, data bits [3:2] become the protection code and data bit 7 becomes the lock bit, both visible on the cycle after the request.
- R5: While `wpN` is low and the lock bit is 1, a write-status request is rejected and neither the protection code nor the lock bit changes.
- R6: While `wpN` is high, a set lock bit does not block a write-status request. This includes a write that clears the lock bit.
- R7: A chip-erase request (`opType`=10) is granted only when the protection code is 00. Otherwise it is denied.
- R8: Every program or erase request produces exactly one of `grant` or `deny`, high for one cycle on the cycle after the request. A cycle without a request produces neither.
- R9: A request with the reserved operation code 11 is always denied.
- R10: `statusOut` shows the lock bit in bit 7 and the protection code in bits [3:2]. All other bits read 0.
- R11: When a write-status request and an operation request arrive in the same cycle, the operation is judged against the protection state held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| wsReq | input | 1 | Write-status request strobe |
| wsData | input | 8 | Data byte carried by the write-status request |
| wpN | input | 1 | Write-protect pin level, active low |
| opReq | input | 1 | Program or erase request strobe |
| opType | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| opAddr | input | ADDR_W | Target byte address of the request |
| protCode | output | 2 | Current protection code |
| lockBit | output | 1 | Current lock bit |
| statusOut | output | 8 | Registered status byte |
| grant | output | 1 | One-cycle pulse: request accepted |
| deny | output | 1 | One-cycle pulse: request refused |
| winLo | output | ADDR_W | Lowest protected address |
| winActive | output | 1 | A protected window exists |

## Verification
A corrupted protection code shows up at once on `protCode`, `statusOut` and the window outputs. It also flips the grant/deny answer to the very next request whose address lies near a window boundary. A lock bit that misbehaves stays invisible until a write-status request arrives with the pin low. The bench therefore writes with the pin low and then checks on the following cycle whether the state moved. Outcome errors appear one cycle after the offending request, because the answer is registered.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_CHIP = 2'b10,
    OP_RSVD = 2'b11
  } opKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStatus;
    logic grantOp;
    logic denyOp;
  } fwpStrobe_t;

  localparam int LOCK_POS = 7;
  localparam int PROT_LO  = 2;
  localparam logic [1:0] PROT_RESET = 2'b11;
endpackage

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
  import fwp_pkg::*;
(
  input  logic       wsReq,
  input  logic       wpN,
  input  logic       lockQ,
  input  logic [1:0] protQ,
  input  logic       opReq,
  input  logic [1:0] opType,
  input  logic       inWindow,
  output fwpStrobe_t strobe
);
  logic writeOpen;
  logic opOk;

  // Lock only counts while the pin is held low
  assign writeOpen = wpN | ~lockQ;

  always_comb begin
    unique case (opKind_t'(opType))
      OP_PROG, OP_SECT: opOk = ~inWindow;
      OP_CHIP:          opOk = (protQ == 2'b00);
      default:          opOk = 1'b0;
    endcase
  end

  always_comb begin
    strobe.loadStatus = wsReq & writeOpen;
    strobe.grantOp    = opReq & opOk;
    strobe.denyOp     = opReq & ~opOk;
  end
endmodule

// File: rtl/fwp_datapath.sv
module fwp_datapath
  import fwp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  fwpStrobe_t        strobe,
  input  logic [7:0]        wsData,
  input  logic [ADDR_W-1:0] opAddr,
  output logic [1:0]        protQ,
  output logic              lockQ,
  output logic [7:0]        statusByte,
  output logic              grantQ,
  output logic              denyQ,
  output logic [ADDR_W-1:0] winLo,
  output logic              winActive,
  output logic              inWindow
);
  localparam logic [ADDR_W:0]   ARRAY_SIZE = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W-1:0] HALF_START = ADDR_W'(ARRAY_SIZE >> 1);
  localparam logic [ADDR_W-1:0] QUAR_START = ADDR_W'(ARRAY_SIZE - (ARRAY_SIZE >> 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      protQ <= PROT_RESET;
      lockQ <= 1'b0;
    end else if (strobe.loadStatus) begin
      protQ <= wsData[PROT_LO +: 2];
      lockQ <= wsData[LOCK_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grantQ <= 1'b0;
      denyQ  <= 1'b0;
    end else begin
      grantQ <= strobe.grantOp;
      denyQ  <= strobe.denyOp;
    end
  end

  always_comb begin
    unique case (protQ)
      2'b01:   winLo = QUAR_START;
      2'b10:   winLo = HALF_START;
      default: winLo = '0;
    endcase
  end

  assign winActive = (protQ != 2'b00);
  assign inWindow  = winActive && (opAddr >= winLo);

  always_comb begin
    statusByte = '0;
    statusByte[LOCK_POS] = lockQ;
    statusByte[PROT_LO +: 2] = protQ;
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import fwp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wsReq,
  input  logic [7:0]        wsData,
  input  logic              wpN,
  input  logic              opReq,
  input  logic [1:0]        opType,
  input  logic [ADDR_W-1:0] opAddr,
  output logic [1:0]        protCode,
  output logic              lockBit,
  output logic [7:0]        statusOut,
  output logic              grant,
  output logic              deny,
  output logic [ADDR_W-1:0] winLo,
  output logic              winActive
);
  fwpStrobe_t strobe;
  logic       inWindow;

  fwp_ctrl u_ctrl (
    .wsReq    (wsReq),
    .wpN      (wpN),
    .lockQ    (lockBit),
    .protQ    (protCode),
    .opReq    (opReq),
    .opType   (opType),
    .inWindow (inWindow),
    .strobe   (strobe)
  );

  fwp_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .wsData     (wsData),
    .opAddr     (opAddr),
    .protQ      (protCode),
    .lockQ      (lockBit),
    .statusByte (statusOut),
    .grantQ     (grant),
    .denyQ      (deny),
    .winLo      (winLo),
    .winActive  (winActive),
    .inWindow   (inWindow)
  );
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wpN,
  input logic              wsReq,
  input logic              opReq,
  input logic [1:0]        opType,
  input logic [ADDR_W-1:0] opAddr,
  input logic [1:0]        protCode,
  input logic              lockBit,
  input logic              grant,
  input logic              deny,
  input logic [ADDR_W-1:0] winLo,
  input logic              winActive
);
  p_locked_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (!wpN && lockBit) |=> ($stable(protCode) && $stable(lockBit)));

  p_chip_erase_deny_r7: assert property (@(posedge clk) disable iff (rst)
    (opReq && opType == 2'b10 && protCode != 2'b00) |=> deny);

  p_window_deny_r2: assert property (@(posedge clk) disable iff (rst)
    (opReq && !opType[1] && winActive && opAddr >= winLo) |=> deny);

  p_no_idle_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    !opReq |=> (!grant && !deny));

  p_one_answer_r8: assert property (@(posedge clk) disable iff (rst)
    opReq |=> (grant != deny));

  p_reserved_deny_r9: assert property (@(posedge clk) disable iff (rst)
    (opReq && opType == 2'b11) |=> deny);

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wsReq |=> ($stable(protCode) && $stable(lockBit)));
endmodule

bind flash_wp_ctrl fwp_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_wp_ctrl_tb.sv
module flash_wp_ctrl_tb;
  localparam int ADDR_W = 16;

  typedef struct packed {
    logic        ws;
    logic [7:0]  wsd;
    logic        wp;
    logic        op;
    logic [1:0]  typ;
    logic [15:0] addr;
    logic        eg;
    logic        ed;
    logic [1:0]  ep;
    logic        el;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd3, 1'b0}, // R2 full after reset
    '{1'b1, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0}, // R4 clear prot
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b0}, // R7 chip erase ok
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 16'hFFFF, 1'b1, 1'b0, 2'd0, 1'b0}, // R2 no window
    '{1'b1, 8'h04, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd1, 1'b0}, // R4 quarter
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 16'hBFFF, 1'b1, 1'b0, 2'd1, 1'b0}, // R2 below quarter
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 16'hC000, 1'b0, 1'b1, 2'd1, 1'b0}, // R2 quarter edge
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd1, 16'hC000, 1'b0, 1'b1, 2'd1, 1'b0}, // R2 sector erase
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b1, 2'd1, 1'b0}, // R7 chip erase denied
    '{1'b1, 8'h08, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd2, 1'b0}, // R4 half
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 16'h7FFF, 1'b1, 1'b0, 2'd2, 1'b0}, // R2 below half
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd0, 16'h8000, 1'b0, 1'b1, 2'd2, 1'b0}, // R2 half edge
    '{1'b1, 8'h8C, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd3, 1'b1}, // R4 set lock
    '{1'b1, 8'h00, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd3, 1'b1}, // R5 rejected
    '{1'b1, 8'h00, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0}, // R6 lock ignored
    '{1'b1, 8'h84, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd1, 1'b1}, // R4 unlocked, pin low
    '{1'b1, 8'h00, 1'b0, 1'b1, 2'd0, 16'hC000, 1'b0, 1'b1, 2'd1, 1'b1}, // R5 reject plus deny
    '{1'b0, 8'h00, 1'b0, 1'b1, 2'd3, 16'h0000, 1'b0, 1'b1, 2'd1, 1'b1}, // R9 reserved
    '{1'b1, 8'h00, 1'b1, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b1, 2'd0, 1'b0}, // R11 old bits judge
    '{1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b0}  // R7 now granted
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              wsReq;
  logic [7:0]        wsData;
  logic              wpN;
  logic              opReq;
  logic [1:0]        opType;
  logic [ADDR_W-1:0] opAddr;
  logic [1:0]        protCode;
  logic              lockBit;
  logic [7:0]        statusOut;
  logic              grant;
  logic              deny;
  logic [ADDR_W-1:0] winLo;
  logic              winActive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  flash_wp_ctrl #(.ADDR_W(ADDR_W)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expLo(input logic [1:0] p);
    case (p)
      2'b01:   return 16'hC000;
      2'b10:   return 16'h8000;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic checkState(input string ctx, input logic [1:0] ep, input logic el);
    chk({"R4 prot ", ctx}, 32'(protCode), 32'(ep));
    chk({"R4 lock ", ctx}, 32'(lockBit), 32'(el));
    chk({"R10 status ", ctx}, 32'(statusOut), 32'({el, 3'b000, ep, 2'b00}));
    chk({"R1 winActive ", ctx}, 32'(winActive), 32'(ep != 2'b00));
    chk({"R1 winLo ", ctx}, 32'(winLo), 32'(expLo(ep)));
  endtask

  task automatic idle();
    wsReq = 1'b0; wsData = 8'h00; opReq = 1'b0; opType = 2'd0; opAddr = '0;
  endtask

  initial begin
    rst = 1'b1; wpN = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    chk("R3 grant after reset", 32'(grant), 32'd0);
    chk("R3 deny after reset", 32'(deny), 32'd0);
    checkState("after reset R3", 2'd3, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wsReq = TBL[i].ws; wsData = TBL[i].wsd; wpN = TBL[i].wp;
      opReq = TBL[i].op; opType = TBL[i].typ; opAddr = TBL[i].addr;
      @(negedge clk);
      idle();
      chk($sformatf("R2 R7 R9 grant row %0d", i), 32'(grant), 32'(TBL[i].eg));
      chk($sformatf("R2 R7 R9 deny row %0d", i), 32'(deny), 32'(TBL[i].ed));
      checkState($sformatf("row %0d", i), TBL[i].ep, TBL[i].el);
    end

    // R8 pulses last one cycle
    opReq = 1'b1; opType = 2'd2; wpN = 1'b1;
    @(negedge clk);
    idle();
    chk("R8 grant pulse present", 32'(grant), 32'd1);
    @(negedge clk);
    chk("R8 grant pulse gone", 32'(grant), 32'd0);
    chk("R8 no deny when idle", 32'(deny), 32'd0);

    // R11 write and program together: judged against prot 00
    wsReq = 1'b1; wsData = 8'h0C; opReq = 1'b1; opType = 2'd0; opAddr = 16'hFFFF;
    @(negedge clk);
    idle();
    chk("R11 program with concurrent write", 32'(grant), 32'd1);
    checkState("R11 after write", 2'd3, 1'b0);

    // R3 reset mid-run restores defaults
    wsReq = 1'b1; wsData = 8'h80; wpN = 1'b1;
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkState("R3 mid-run reset", 2'd3, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule